// File: doc/BRIEF.md
# Learned IR Code Slot Store

This controller captures an infrared remote code, learned as a fixed number of bytes, and keeps it in one of a small set of memory slots. It can later send a stored code back out, one byte at a time, toward a serial transmitter. A host pulses `learn_go` to begin capturing. The demodulated code bytes then arrive on a valid/ready receive stream. An outside state machine picks a slot by presenting `replay_slot` and pulsing `replay_req`, in the manner of an interrupt.

Captured bytes go first into a scratch region of the on-chip byte store. When the last byte has arrived, the controller looks in an occupancy map for the lowest-numbered free slot. In that map a 1 bit means free and a 0 bit means taken. If a slot is free, the controller claims it and copies the scratch bytes into it. If no slot is free, it overwrites the scratch region with zeros and flags that memory is full.

Both byte streams follow the usual valid/ready rule: a byte moves on a clock edge where valid and ready are both high. The receive side raises `rx_ready` only while capturing, so an upstream source that holds `rx_valid` low simply stalls the capture. On the transmit side, `tx_byte` and `tx_valid` stay unchanged while `tx_ready` is low, so a slow transmitter loses nothing.

Top module: `ir_code_store`

## Requirements
- R1: After reset, `rx_ready`, `tx_valid`, `done`, `mem_full` and `replay_err` are all 0, and every slot is free.
- R2: After a `learn_go` pulse in idle, `rx_ready` is 1 until exactly CODE_LEN bytes have been taken, and then it drops. A `learn_go` pulse during a capture is ignored and does not restart the byte count.
- R3: Each successful capture claims the lowest-numbered free slot, so successive codes fill slots 0, 1, 2, ... in order, and a claimed slot stays taken.
- R4: A successful capture ends with a one-cycle `done` pulse, with `mem_full` low.
- R5: A replay request with `replay_slot` naming a taken slot sends that slot's CODE_LEN bytes on the transmit stream, in the order they were received.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_byte` hold their values.
- R7: Cycles with `rx_valid` low during a capture neither add nor drop bytes.
- R8: When no slot is free, a finished capture is thrown away. `done` and `mem_full` pulse together for one cycle, and every stored slot keeps its contents.
- R9: A replay request for a free slot, or for a `replay_slot` value of NSLOT or more, gives a single one-cycle `replay_err` pulse. It sends no byte and gives no `done`.
- R10: A replay request that arrives during a capture is held. No byte is sent until the capture has been stored, and then the requested replay runs.
- R11: A replay ends with a one-cycle `done` pulse in the cycle after its last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| learn_go | input | 1 | Pulse: start capturing a code |
| rx_byte | input | 8 | Received code byte |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Controller takes a receive byte |
| replay_slot | input | 3 | Slot number to replay, latched on `replay_req` |
| replay_req | input | 1 | Pulse: replay the selected slot |
| tx_byte | output | 8 | Byte to the serial transmitter |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Transmitter takes the byte |
| done | output | 1 | One-cycle pulse: store or replay finished |
| mem_full | output | 1 | One-cycle pulse: capture discarded, no free slot |
| replay_err | output | 1 | One-cycle pulse: replay refused |

## Verification
The hardest situations to reach from the ports are a replay request that arrives in the middle of a capture and the full-memory path. The first needs `replay_req` pulsed between receive handshakes, and the bench then checks that `tx_valid` stays low until the store has finished. The second is reached only after every slot has been filled through the normal learn sequence. A further capture is then made, and earlier slots are replayed to show that the discarded code left them untouched.

// File: rtl/ir_store_pkg.sv
package ir_store_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEARN,
    ST_ALLOC,
    ST_COPY,
    ST_WIPE,
    ST_PLAY
  } ctl_state_t;

endpackage

// File: rtl/ir_slot_pick.sv
module ir_slot_pick #(
  parameter int NSLOT = 4,
  parameter int IDX_W = 2
) (
  input  logic [NSLOT-1:0] free_map,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (free_map[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end

  always_comb begin
    if (found) begin
      AST_PICK_IS_FREE: assert (free_map[idx]); // R3
      AST_PICK_LOWEST: assert ((free_map & ((NSLOT'(1) << idx) - NSLOT'(1))) == '0); // R3
    end
  end

endmodule

// File: rtl/ir_byte_bank.sv
module ir_byte_bank #(
  parameter int DEPTH = 40,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ir_code_store.sv
module ir_code_store
  import ir_store_pkg::*;
#(
  parameter int NSLOT    = 4,
  parameter int CODE_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       learn_go,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [2:0] replay_slot,
  input  logic       replay_req,
  output logic [7:0] tx_byte,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic       done,
  output logic       mem_full,
  output logic       replay_err
);

  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int CNT_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;
  localparam int DEPTH = (NSLOT + 1) * CODE_LEN;
  localparam int AW    = $clog2(DEPTH);
  localparam int SCRATCH = NSLOT;  // region index of the scratch buffer

  ctl_state_t       state;
  logic [CNT_W-1:0] idx;
  logic [IDX_W-1:0] slot;
  logic [NSLOT-1:0] free_map;
  logic             pend;
  logic [2:0]       pend_slot;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             last;
  logic             we;
  logic [AW-1:0]    waddr;
  logic [AW-1:0]    raddr;
  logic [7:0]       wdata;
  logic [7:0]       rdata;
  logic             pend_bad;

  function automatic logic [AW-1:0] at(input int region, input int off);
    return AW'(region * CODE_LEN + off);
  endfunction

  ir_slot_pick #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_pick (
    .free_map (free_map),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  ir_byte_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign last     = (idx == CNT_W'(CODE_LEN - 1));
  assign rx_ready = (state == ST_LEARN);
  assign tx_valid = (state == ST_PLAY);
  assign tx_byte  = rdata;
  assign pend_bad = (32'(pend_slot) >= NSLOT) || free_map[pend_slot[IDX_W-1:0]];

  always_comb begin
    we    = 1'b0;
    waddr = at(SCRATCH, int'(idx));
    wdata = 8'h00;
    case (state)
      ST_LEARN: begin
        we    = rx_valid;
        wdata = rx_byte;
      end
      ST_COPY: begin
        we    = 1'b1;
        waddr = at(int'(slot), int'(idx));
        wdata = rdata;
      end
      ST_WIPE: we = 1'b1;
      default: ;
    endcase
    raddr = (state == ST_PLAY) ? at(int'(slot), int'(idx)) : at(SCRATCH, int'(idx));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      slot       <= '0;
      free_map   <= '1;
      pend       <= 1'b0;
      pend_slot  <= '0;
      done       <= 1'b0;
      mem_full   <= 1'b0;
      replay_err <= 1'b0;
    end else begin
      done       <= 1'b0;
      mem_full   <= 1'b0;
      replay_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (learn_go) begin
            state <= ST_LEARN;
          end else if (pend) begin
            pend <= 1'b0;
            if (pend_bad) begin
              replay_err <= 1'b1;
            end else begin
              slot  <= pend_slot[IDX_W-1:0];
              state <= ST_PLAY;
            end
          end
        end
        ST_LEARN: begin
          if (rx_valid) begin
            idx <= idx + 1'b1;
            if (last) state <= ST_ALLOC;
          end
        end
        ST_ALLOC: begin
          idx <= '0;
          if (pick_found) begin
            free_map[pick_idx] <= 1'b0;
            slot               <= pick_idx;
            state              <= ST_COPY;
          end else begin
            state <= ST_WIPE;
          end
        end
        ST_COPY, ST_WIPE: begin
          idx <= idx + 1'b1;
          if (last) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            mem_full <= (state == ST_WIPE);
          end
        end
        ST_PLAY: begin
          if (tx_ready) begin
            idx <= idx + 1'b1;
            if (last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (replay_req) begin
        pend      <= 1'b1;
        pend_slot <= replay_slot;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte)); // R6
  AST_SLOT_STAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (free_map & ~$past(free_map)) == '0); // R3
  AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(free_map)) <= $countones(free_map) + 1); // R3
  AST_FULL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |-> done && free_map == '0); // R8
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    replay_err |-> !tx_valid && !done); // R9
  AST_NO_SEND_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_ready) && !rx_ready |-> !tx_valid); // R10

endmodule

// File: tb/ir_code_store_test.sv
`timescale 1ns/1ps
module ir_code_store_test;

  localparam int NSLOT    = 4;
  localparam int CODE_LEN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       learn_go = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [2:0] replay_slot = '0;
  logic       replay_req = 1'b0;
  logic [7:0] tx_byte;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic       done;
  logic       mem_full;
  logic       replay_err;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  ir_code_store #(.NSLOT(NSLOT), .CODE_LEN(CODE_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .learn_go(learn_go), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .replay_slot(replay_slot),
    .replay_req(replay_req), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .done(done), .mem_full(mem_full), .replay_err(replay_err)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 29 + i * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // capture one code; optional idle gaps, stray learn_go, replay request mid-way
  task automatic learn(input int seed, input int gap, input bit stray_go,
                       input bit req_mid, input logic [2:0] req_slot, output bit full);
    bit ok;
    bit tx_seen;
    bit got;
    full = 1'b0;
    tx_seen = 1'b0;
    @(negedge clk); learn_go = 1'b1;
    @(negedge clk); learn_go = 1'b0;
    for (int i = 0; i < CODE_LEN; i++) begin
      rx_valid = 1'b1;
      rx_byte  = pat(seed, i);
      if (stray_go && i == 3) learn_go = 1'b1;
      if (req_mid && i == 2) begin replay_req = 1'b1; replay_slot = req_slot; end
      for (int t = 0; t < 100; t++) begin
        ok = rx_ready;
        if (tx_valid) tx_seen = 1'b1;
        @(negedge clk);
        learn_go = 1'b0;
        replay_req = 1'b0;
        if (ok) break;
      end
      rx_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin
        if (tx_valid) tx_seen = 1'b1;
        @(negedge clk);
      end
    end
    check(rx_ready == 1'b0, "R2 ready drops after CODE_LEN bytes", rx_ready, 0);
    got = 1'b0;
    for (int t = 0; t < 40; t++) begin
      if (tx_valid) tx_seen = 1'b1;
      if (done) begin got = 1'b1; full = mem_full; break; end
      @(negedge clk);
    end
    check(got, "R4 done after capture", got, 1);
    if (req_mid) check(!tx_seen, "R10 no send before store", tx_seen, 0);
    @(negedge clk);
    check(done == 1'b0, "R4 done is one cycle", done, 0);
  endtask

  task automatic request(input logic [2:0] s);
    @(negedge clk); replay_req = 1'b1; replay_slot = s;
    @(negedge clk); replay_req = 1'b0;
  endtask

  // gather one code from the transmit side; stall cycles before each byte
  task automatic collect(input int seed, input int stall, input string req);
    logic [7:0] held;
    bit bad;
    bad = 1'b0;
    for (int i = 0; i < CODE_LEN; i++) begin
      for (int t = 0; t < 60 && !tx_valid; t++) @(negedge clk);
      if (!tx_valid) begin check(1'b0, req, 0, 1); return; end
      if (stall > 0) begin
        held = tx_byte;
        for (int s = 0; s < stall; s++) @(negedge clk);
        check(tx_valid && tx_byte == held, "R6 byte held under stall", tx_byte, held);
      end
      tx_ready = 1'b1;
      if (tx_byte != pat(seed, i)) begin
        bad = 1'b1;
        check(1'b0, req, tx_byte, pat(seed, i));
      end
      @(negedge clk);
      tx_ready = 1'b0;
    end
    check(!bad, req, bad, 0);
    check(done == 1'b1, "R11 done after last byte", done, 1);
    @(negedge clk);
    check(done == 1'b0 && tx_valid == 1'b0, "R11 replay ended", done, 0);
  endtask

  task automatic expect_refusal(input logic [2:0] s);
    int errs;
    bit quiet;
    errs = 0;
    quiet = 1'b1;
    request(s);
    for (int t = 0; t < 10; t++) begin
      if (replay_err) errs++;
      if (tx_valid || done) quiet = 1'b0;
      @(negedge clk);
    end
    check(errs == 1, "R9 single replay_err pulse", errs, 1);
    check(quiet, "R9 nothing sent", quiet, 1);
  endtask

  task automatic t_reset;
    check(!rx_ready && !tx_valid && !done && !mem_full && !replay_err,
          "R1 outputs idle after reset",
          {rx_ready, tx_valid, done, mem_full, replay_err}, 0);
    expect_refusal(3'd0);  // R1 slot 0 starts free
  endtask

  task automatic t_fill_and_play;
    bit full;
    learn(1, 0, 1'b0, 1'b0, 3'd0, full);
    check(!full, "R4 mem_full low on store", full, 0);
    request(3'd0);
    collect(1, 0, "R5 slot 0 replay");
    learn(2, 2, 1'b1, 1'b0, 3'd0, full);   // R7 gaps, R2 stray learn_go
    request(3'd1);
    collect(2, 3, "R7 gapped capture in slot 1");
    learn(3, 0, 1'b0, 1'b1, 3'd1, full);   // R10 request during capture
    collect(2, 0, "R10 held replay of slot 1");
    learn(4, 1, 1'b0, 1'b0, 3'd0, full);
    request(3'd3);
    collect(4, 0, "R3 fourth code in slot 3");
    request(3'd2);
    collect(3, 1, "R3 third code in slot 2");
  endtask

  task automatic t_full;
    bit full;
    learn(9, 0, 1'b0, 1'b0, 3'd0, full);
    check(full, "R8 mem_full with done", full, 1);
    request(3'd0);
    collect(1, 0, "R8 slot 0 unchanged");
    request(3'd2);
    collect(3, 0, "R8 slot 2 unchanged");
    expect_refusal(3'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_play();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule